// File: doc/BRIEF.md
# Five-Level Inverter Gate Pattern Generator

This block produces the six gate-drive bits for a symmetric cascaded bridge that can place five voltage levels (-2, -1, 0, +1, +2 times the source voltage) across its load. A 4-bit state counter walks through sixteen states per output period. Fixed sum-of-products logic turns each state into a gate word. The counter's top bit picks the polarity half of the period. The counter advances only on ticks from an internal prescaler, so the time spent in each state, and with it the output frequency, can be changed at run time through `period_i`.

Each registered gate word is also classified against the five legal switch pairs. The block reports the level it is commanding as a signed code, and it raises a fault flag for any gate word that is not one of those pairs. A one-cycle strobe marks the first cycle of every new output period. Driving `en_i` low, or holding reset, clears all outputs and returns the state counter and the prescaler to zero.

Top module: `ml5_gate_sequencer`

## Requirements
- R1: While `rst_i` is high, and in the cycle after any edge at which `en_i` was low, `gate_o`, `level_o`, `fault_o` and `period_start_o` are all 0.
- R2: Each counter state is held for exactly `period_i`+1 clock cycles. A value of 0 advances the counter on every cycle.
- R3: A period has 16 states. State bit 3 (D) selects the half: S1 (`gate_o[0]`) can be high only when D=0, S2 (`gate_o[1]`) only when D=1, and they are never high together.
- R4: With state bits D C B A (D is bit 3, A is bit 0), S1 = !D&(C&!A | !B&A | !C&B), and S2 is the same product terms gated by D.
- R5: S3 (`gate_o[2]`) = !D&(C&!B | !C&B) | !C&!B&!A | C&B&A, and S4 (`gate_o[3]`) = D&(C&!B | !C&B) | !C&!B&!A | C&B&A.
- R6: S5 (`gate_o[4]`) = !D&(C&B&A | !C&!B&A), and S6 (`gate_o[5]`) = D&(C&B&!A | !C&!B&!A).
- R7: `level_o` is a 3-bit two's-complement code: +2 when exactly S1 and S3 are on, +1 for S1 and S5, 0 for S3 and S4, -1 for S2 and S6, -2 for S2 and S4.
- R8: When enabled, `fault_o` is 1 exactly when `gate_o` is not one of the five pairs in R7, and `level_o` is then 0. This happens in counter states 6, 7, 8 and 9.
- R9: `period_start_o` is high for one cycle, in the first cycle in which `gate_o` shows the state-0 word after the counter wraps from 15 to 0. It therefore recurs every 16*(`period_i`+1) cycles. It does not fire when the block is first enabled.
- R10: All outputs share one cycle of latency from the counter. After `en_i` rises, the state-0 word appears in the next cycle and is held for a full `period_i`+1 cycles, even if the run was stopped in the middle of a state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low clears the state and the outputs |
| period_i | input | PERIOD_W | Extra clock cycles per counter state (dwell = value + 1) |
| gate_o | output | 6 | Gate bits, bit 0 = S1 through bit 5 = S6 |
| level_o | output | 3 | Signed commanded level, -2 to +2 |
| fault_o | output | 1 | Gate word is not one of the five legal pairs |
| period_start_o | output | 1 | One-cycle strobe at the start of each output period |

## Verification
The full sixteen-state walk is run with state dwells of one, three and six cycles. Every state word, level code and fault bit is compared against a table written out by hand in the bench. The one-cycle dwell exposes any off-by-one in the prescaler compare, and the longer dwells show that outputs are held steady within a state. Stopping the run in the middle of a state and then restarting it shows whether both the prescaler and the counter were cleared, and not just the outputs. Counting the strobes across a period separates a wrap-only strobe from one that also fires on enable.

// File: rtl/ml5_gate_pkg.sv
package ml5_gate_pkg;
  localparam int STATE_W   = 4;
  localparam int NUM_GATES = 6;
  localparam int LEVEL_W   = 3;
  localparam int NUM_STATES = 1 << STATE_W;

  typedef logic [NUM_GATES-1:0]      gate_vec_t;
  typedef logic signed [LEVEL_W-1:0] level_t;
  typedef logic [STATE_W-1:0]        state_t;

  // legal switch pairs, bit 0 = S1 .. bit 5 = S6
  localparam gate_vec_t PAIR_POS2 = 6'b000101; // S1,S3
  localparam gate_vec_t PAIR_POS1 = 6'b010001; // S1,S5
  localparam gate_vec_t PAIR_ZERO = 6'b001100; // S3,S4
  localparam gate_vec_t PAIR_NEG1 = 6'b100010; // S2,S6
  localparam gate_vec_t PAIR_NEG2 = 6'b001010; // S2,S4
endpackage

// File: rtl/ml5_tick_prescaler.sv
module ml5_tick_prescaler #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] count_q;

  // >= keeps a period shrink from running the count through a full wrap
  assign tick_o = en_i && (count_q >= period_i);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      count_q <= '0;
    end else if (tick_o) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/ml5_phase_counter.sv
module ml5_phase_counter
  import ml5_gate_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   en_i,
  input  logic   tick_i,
  output state_t state_o,
  output logic   wrap_o
);
  localparam state_t LAST_STATE = state_t'(NUM_STATES - 1);

  state_t state_q;

  assign state_o = state_q;
  assign wrap_o  = tick_i && (state_q == LAST_STATE);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      state_q <= '0;
    end else if (tick_i) begin
      state_q <= state_q + 1'b1;
    end
  end
endmodule

// File: rtl/ml5_switch_decode.sv
module ml5_switch_decode
  import ml5_gate_pkg::*;
(
  input  state_t    state_i,
  output gate_vec_t gate_o
);
  logic bd, bc, bb, ba;
  logic edge_terms, mid_terms, common_terms;

  assign bd = state_i[3];
  assign bc = state_i[2];
  assign bb = state_i[1];
  assign ba = state_i[0];

  // product terms shared by both halves
  assign edge_terms   = (bc & ~ba) | (~bb & ba) | (~bc & bb);
  assign mid_terms    = (bc & ~bb) | (~bc & bb);
  assign common_terms = (~bc & ~bb & ~ba) | (bc & bb & ba);

  // half 0 drives S1/S3/S5 (D low), half 1 drives S2/S4/S6 (D high)
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic sel;
    logic a_pol;
    assign sel   = (h == 0) ? ~bd : bd;
    assign a_pol = (h == 0) ? ba : ~ba;

    assign gate_o[h]     = sel & edge_terms;
    assign gate_o[2 + h] = (sel & mid_terms) | common_terms;
    assign gate_o[4 + h] = sel & ((bc & bb & a_pol) | (~bc & ~bb & a_pol));
  end
endmodule

// File: rtl/ml5_level_classify.sv
module ml5_level_classify
  import ml5_gate_pkg::*;
(
  input  gate_vec_t gate_i,
  output level_t    level_o,
  output logic      fault_o
);
  always_comb begin
    fault_o = 1'b0;
    unique case (gate_i)
      PAIR_POS2: level_o = 3'sd2;
      PAIR_POS1: level_o = 3'sd1;
      PAIR_ZERO: level_o = 3'sd0;
      PAIR_NEG1: level_o = -3'sd1;
      PAIR_NEG2: level_o = -3'sd2;
      default: begin
        level_o = 3'sd0;
        fault_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ml5_gate_sequencer.sv
module ml5_gate_sequencer
  import ml5_gate_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [5:0]          gate_o,
  output logic signed [2:0]   level_o,
  output logic                fault_o,
  output logic                period_start_o
);
  logic      tick;
  logic      wrap;
  state_t    state;
  gate_vec_t gate_next;
  level_t    level_next;
  logic      fault_next;
  logic      wrap_q;

  gate_vec_t gate_q;
  level_t    level_q;
  logic      fault_q;
  logic      strobe_q;

  ml5_tick_prescaler #(.PERIOD_W(PERIOD_W)) u_prescale (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .period_i (period_i),
    .tick_o   (tick)
  );

  ml5_phase_counter u_phase (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .tick_i  (tick),
    .state_o (state),
    .wrap_o  (wrap)
  );

  ml5_switch_decode u_decode (
    .state_i (state),
    .gate_o  (gate_next)
  );

  ml5_level_classify u_classify (
    .gate_i  (gate_next),
    .level_o (level_next),
    .fault_o (fault_next)
  );

  // output stage: all outputs carry the same one-cycle lag behind the counter
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      gate_q   <= '0;
      level_q  <= '0;
      fault_q  <= 1'b0;
      wrap_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      gate_q   <= gate_next;
      level_q  <= level_next;
      fault_q  <= fault_next;
      wrap_q   <= wrap;
      strobe_q <= wrap_q;
    end
  end

  assign gate_o         = gate_q;
  assign level_o        = level_q;
  assign fault_o        = fault_q;
  assign period_start_o = strobe_q;
endmodule

// File: rtl/ml5_gate_sequencer_chk.sv
module ml5_gate_sequencer_chk (
  input logic              clk_i,
  input logic              rst_i,
  input logic              en_i,
  input logic [5:0]        gate_o,
  input logic signed [2:0] level_o,
  input logic              fault_o,
  input logic              period_start_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (gate_o == 6'b0 && level_o == 3'sd0 && !fault_o && !period_start_o));

  a_r3_halves_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
    !(gate_o[0] && gate_o[1]));

  a_r7_positive_needs_s1: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_o > 3'sd0) |-> gate_o[0]);

  a_r7_negative_needs_s2: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_o < 3'sd0) |-> gate_o[1]);

  a_r7_level_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_o >= -3'sd2) && (level_o <= 3'sd2));

  a_r7_two_switches_when_legal: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && $past(en_i) && !fault_o) |-> ($countones(gate_o) == 2));

  a_r8_fault_level_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_o |-> (level_o == 3'sd0));

  a_r9_strobe_single: assert property (@(posedge clk_i) disable iff (rst_i)
    period_start_o |=> !period_start_o);

  a_r9_strobe_on_zero_word: assert property (@(posedge clk_i) disable iff (rst_i)
    period_start_o |-> (gate_o == 6'b001100));
endmodule

bind ml5_gate_sequencer ml5_gate_sequencer_chk u_chk (
  .clk_i          (clk_i),
  .rst_i          (rst_i),
  .en_i           (en_i),
  .gate_o         (gate_o),
  .level_o        (level_o),
  .fault_o        (fault_o),
  .period_start_o (period_start_o)
);

// File: tb/test_ml5_gate_sequencer.sv
`timescale 1ns/1ps
module test_ml5_gate_sequencer;
  localparam int PW = 16;

  logic              clk_i = 1'b0;
  logic              rst_i = 1'b1;
  logic              en_i  = 1'b0;
  logic [PW-1:0]     period_i = '0;
  logic [5:0]        gate_o;
  logic signed [2:0] level_o;
  logic              fault_o;
  logic              period_start_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  ml5_gate_sequencer #(.PERIOD_W(PW)) i_ml5_gate_sequencer (
    .clk_i, .rst_i, .en_i, .period_i,
    .gate_o, .level_o, .fault_o, .period_start_o
  );

  // expected gate word per state, bit 0 = S1 .. bit 5 = S6
  function automatic logic [5:0] exp_gate(input int s);
    case (s)
      0:  return 6'b001100;
      1:  return 6'b010001;
      2, 3, 4, 5: return 6'b000101;
      6:  return 6'b000001;
      7:  return 6'b011100;
      8:  return 6'b101100;
      9:  return 6'b000010;
      10, 11, 12, 13: return 6'b001010;
      14: return 6'b100010;
      default: return 6'b001100;
    endcase
  endfunction

  function automatic int exp_level(input int s);
    case (s)
      1: return 1;
      2, 3, 4, 5: return 2;
      10, 11, 12, 13: return -2;
      14: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_fault(input int s);
    return (s >= 6 && s <= 9);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_state(input int s, input bit strobe_exp);
    string t;
    t = (s < 8) ? "R4/R5/R6 gates (positive half)" : "R4/R5/R6 gates (negative half)";
    chk(gate_o == exp_gate(s), t, gate_o, exp_gate(s));
    chk(int'(level_o) == exp_level(s), "R7 level", level_o, exp_level(s));
    chk(fault_o == exp_fault(s), "R8 fault", fault_o, exp_fault(s));
    chk(period_start_o == strobe_exp, "R9 strobe", period_start_o, strobe_exp);
    chk(!(gate_o[0] && gate_o[1]), "R3 halves", gate_o[1:0], 0);
  endtask

  task automatic t_reset();
    rst_i = 1'b1; en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(gate_o == 6'b0, "R1 reset gates", gate_o, 0);
    chk(level_o == 3'sd0 && !fault_o, "R1 reset level/fault", {level_o, fault_o}, 0);
    chk(!period_start_o, "R1 reset strobe", period_start_o, 0);
    rst_i = 1'b0;
    @(negedge clk_i);
  endtask

  // full period walk with dwell p+1 (R2, R3..R9)
  task automatic t_run(input int p);
    int waited;
    period_i = PW'(p);
    en_i = 1'b1;
    waited = 0;
    @(negedge clk_i);
    while (!period_start_o && waited < 20 * 16 * (p + 1)) begin
      @(negedge clk_i);
      waited++;
    end
    chk(period_start_o, "R9 strobe seen", period_start_o, 1);
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c <= p; c++) begin
        check_state(s, (s == 0 && c == 0));
        @(negedge clk_i);
      end
    end
    chk(period_start_o && gate_o == exp_gate(0), "R2/R9 next period start",
        period_start_o, 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(gate_o == 6'b0 && !period_start_o, "R1 disable clears", gate_o, 0);
  endtask

  // stop mid-state, restart: state 0 dwells full p+1 (R10, R1)
  task automatic t_restart(input int p);
    int strobes;
    period_i = PW'(p);
    en_i = 1'b1;
    repeat (3 * (p + 1) + p / 2 + 1) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(gate_o == 6'b0 && level_o == 3'sd0 && !fault_o && !period_start_o,
        "R1 mid-run disable", gate_o, 0);
    en_i = 1'b1;
    strobes = 0;
    @(negedge clk_i);
    for (int c = 0; c <= p; c++) begin
      chk(gate_o == exp_gate(0), "R10 restart state 0 dwell", gate_o, exp_gate(0));
      if (period_start_o) strobes++;
      @(negedge clk_i);
    end
    chk(gate_o == exp_gate(1), "R10 then state 1", gate_o, exp_gate(1));
    chk(strobes == 0, "R9 no strobe on enable", strobes, 0);
    strobes = 0;
    for (int c = 0; c < 32 * (p + 1); c++) begin
      if (period_start_o) strobes++;
      @(negedge clk_i);
    end
    chk(strobes == 2, "R9 strobe rate", strobes, 2);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    t_reset();
    t_run(0);
    t_run(2);
    t_run(5);
    t_restart(3);
    t_restart(0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule